// File: doc/BRIEF.md
# Conversion Cycle Sequencer with Power Control

This block runs in the conversion-clock domain and times every operation that the instruction decoder launches. A conversion passes through a single synchronization cycle, then an acquisition window whose length is selected by a two-bit code, and then a fixed conversion window. A calibration or zero-offset cycle lasts until the converter core reports that it has finished. Power transitions are also handled here: the hardware power-down pin, software power commands, and a timed power-up phase. An active-low busy indication (`eoc`, high only when the sequencer is idle) rises at the end of every such cycle.

A chip-select falling event cuts a running conversion short and returns the sequencer to idle. The hardware pin overrides everything else, and it interacts asymmetrically with the software commands. Whenever a conversion ends, whether normally or by an abort, a one-cycle capture strobe tells the result register to latch the core output. A companion flag marks the latched word as trustworthy or not. The strobe is a plain pulse with no back-pressure, because the result register must accept it in the cycle it appears. Status flags give the current activity of the sequencer.

Top module: `cnv_cycle_seq`

## Requirements
- R1: After reset `eoc` is high, every status flag (`st_conv`, `st_cal`, `st_zero`, `st_pwrup`, `st_pwrdn`) is low and `cap_stb` is low.
- R2: `eoc` is low in every cycle in which a conversion, calibration, zero-offset, power-up or power-down activity is in progress, and high only when the sequencer is idle.
- R3: `cmd_conv` sampled high in idle in cycle t makes `eoc` low from cycle t+1 for exactly 1 + A + CONV_CYC cycles. A is the acquisition length taken from `acq_sel` at the edge that ends the synchronization cycle: code 0 gives 6, code 1 gives 10, code 2 gives 18 and code 3 gives 34 cycles.
- R4: A conversion that completes normally raises `cap_stb` for one cycle with `cap_ok` high, in the first cycle that `eoc` is high again. `cap_stb` is never raised unless a conversion was in progress in the previous cycle.
- R5: `cs_fall` sampled high while a conversion is in progress makes `eoc` high, `cap_stb` high and `cap_ok` low in the next cycle. `cs_fall` outside a conversion has no effect.
- R6: `cmd_cal` (or `cmd_zero`) in idle holds `st_cal` (or `st_zero`) high and `eoc` low from the next cycle until the cycle after `core_done` is sampled high. These cycles never raise `cap_stb`. `core_done` has no effect in any other state.
- R7: `pd_pin` sampled high in any state makes `st_pwrdn` high and `eoc` low in the next cycle. If a conversion was in progress, that cycle also carries `cap_stb` high with `cap_ok` low.
- R8: While `pd_pin` is high, `cmd_pwr_up` and `cmd_pwr_dn` have no effect and the block stays powered down.
- R9: `cmd_pwr_dn` with `pd_pin` low powers the block down in the next cycle from any state. A conversion it interrupts is flagged exactly as in R7.
- R10: Power is restored by `cmd_pwr_up` after a software power-down, or by `pd_pin` going high and then low. Either path gives exactly PWRUP_CYC cycles of `st_pwrup` with `eoc` low, after which the sequencer is idle.
- R11: `cmd_conv`, `cmd_cal` and `cmd_zero` are ignored unless the sequencer is idle. In idle the order of precedence is calibration, then zero-offset, then conversion.
- R12: At most one status flag is high at a time. `st_conv` is high exactly while a conversion is in synchronization, acquisition or conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_conv | input | 1 | One-cycle pulse: start a conversion |
| cmd_cal | input | 1 | One-cycle pulse: start calibration |
| cmd_zero | input | 1 | One-cycle pulse: start zero-offset cycle |
| cmd_pwr_up | input | 1 | One-cycle pulse: software power-up |
| cmd_pwr_dn | input | 1 | One-cycle pulse: software power-down |
| acq_sel | input | 2 | Acquisition length code (6/10/18/34 cycles) |
| cs_fall | input | 1 | One-cycle pulse: chip-select falling event |
| pd_pin | input | 1 | Hardware power-down level, high = down |
| core_done | input | 1 | Converter core has finished calibration or zero-offset |
| eoc | output | 1 | High when idle, low while any cycle is running |
| st_conv | output | 1 | Conversion in progress |
| st_cal | output | 1 | Calibration in progress |
| st_zero | output | 1 | Zero-offset cycle in progress |
| st_pwrup | output | 1 | Power-up phase in progress |
| st_pwrdn | output | 1 | Powered down |
| cap_stb | output | 1 | One-cycle result capture strobe |
| cap_ok | output | 1 | With `cap_stb`: result is valid |

## Verification
A wrong state or timer value shows at the ports within one cycle. It appears either as `eoc` rising early or late, or as a status flag that disagrees with the activity that should be in progress. A miscounted acquisition or power-up window moves the `eoc` rising edge, and with it the capture strobe, by the size of the error. A lost software power-down flag appears as an early `st_pwrup`. The reference model in the bench is compared against every output on every cycle, so any divergence is reported at the first cycle it is visible.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_SYNC = 3'd1,
    SQ_ACQ  = 3'd2,
    SQ_CONV = 3'd3,
    SQ_CAL  = 3'd4,
    SQ_ZERO = 3'd5,
    SQ_PUP  = 3'd6,
    SQ_PDN  = 3'd7
  } sq_state_e;

  // Longest acquisition window for a selector of the given width:
  // code k maps to 2^(k+2) + 2 cycles.
  function automatic int acq_max_len(input int sel_w);
    return (1 << ((1 << sel_w) + 1)) + 2;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cnv_acq_len.sv
module cnv_acq_len #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 6
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] len
);

  localparam int NCODES = 1 << SEL_W;

  logic [CNT_W-1:0] lut [NCODES];

  // Each code doubles the window and adds a fixed two-cycle settling margin.
  for (genvar k = 0; k < NCODES; k++) begin : g_len
    assign lut[k] = CNT_W'((1 << (k + 2)) + 2);
  end

  assign len = lut[sel];

endmodule

// File: rtl/cnv_cycle_timer.sv
module cnv_cycle_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  // Loading N makes the expiry flag appear in the Nth cycle after the load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(cnt) == '0 && $past(!load)) |-> (cnt == '0)); // R3

endmodule

// File: rtl/cnv_power_ctl.sv
module cnv_power_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_pin,
  input  logic sw_up,
  input  logic sw_dn,
  output logic pwr_off
);

  logic sw_pd;
  logic sw_pd_nxt;

  // The pin dominates: while it is high the software flag is cleared, so a
  // later fall of the pin restores power. Software commands act only with
  // the pin low; power-down wins over power-up.
  always_comb begin
    if (pd_pin)      sw_pd_nxt = 1'b0;
    else if (sw_dn)  sw_pd_nxt = 1'b1;
    else if (sw_up)  sw_pd_nxt = 1'b0;
    else             sw_pd_nxt = sw_pd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_pd <= 1'b0;
    else        sw_pd <= sw_pd_nxt;
  end

  assign pwr_off = pd_pin | sw_pd_nxt;

  AST_PIN_CLEARS_SW: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pin |=> !sw_pd); // R10

  AST_SW_DN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pd && !pd_pin && !sw_up) |-> pwr_off); // R9

endmodule

// File: rtl/cnv_cycle_seq.sv
module cnv_cycle_seq
  import cnv_seq_pkg::*;
#(
  parameter int ACQ_SEL_W = 2,
  parameter int CONV_CYC  = 20,
  parameter int PWRUP_CYC = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_conv,
  input  logic                 cmd_cal,
  input  logic                 cmd_zero,
  input  logic                 cmd_pwr_up,
  input  logic                 cmd_pwr_dn,
  input  logic [ACQ_SEL_W-1:0] acq_sel,
  input  logic                 cs_fall,
  input  logic                 pd_pin,
  input  logic                 core_done,
  output logic                 eoc,
  output logic                 st_conv,
  output logic                 st_cal,
  output logic                 st_zero,
  output logic                 st_pwrup,
  output logic                 st_pwrdn,
  output logic                 cap_stb,
  output logic                 cap_ok
);

  localparam int MAX_LEN = max3(acq_max_len(ACQ_SEL_W), CONV_CYC, PWRUP_CYC);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  sq_state_e        st, st_n;
  logic             pwr_off;
  logic             in_conv;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic [CNT_W-1:0] acq_len;
  logic             cap_n, ok_n;

  cnv_power_ctl u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_pin  (pd_pin),
    .sw_up   (cmd_pwr_up),
    .sw_dn   (cmd_pwr_dn),
    .pwr_off (pwr_off)
  );

  cnv_acq_len #(
    .SEL_W (ACQ_SEL_W),
    .CNT_W (CNT_W)
  ) u_acq (
    .sel (acq_sel),
    .len (acq_len)
  );

  cnv_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign in_conv = (st == SQ_SYNC) || (st == SQ_ACQ) || (st == SQ_CONV);

  // Priority: power-off, then the power-up launch, then chip-select abort,
  // then the per-state sequencing.
  always_comb begin
    st_n     = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_n    = 1'b0;
    ok_n     = 1'b0;
    if (pwr_off) begin
      st_n  = SQ_PDN;
      cap_n = in_conv;
    end else if (st == SQ_PDN) begin
      st_n     = SQ_PUP;
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(PWRUP_CYC);
    end else if (in_conv && cs_fall) begin
      st_n  = SQ_IDLE;
      cap_n = 1'b1;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (cmd_cal)       st_n = SQ_CAL;
          else if (cmd_zero) st_n = SQ_ZERO;
          else if (cmd_conv) st_n = SQ_SYNC;
        end
        SQ_SYNC: begin
          st_n     = SQ_ACQ;
          tmr_load = 1'b1;
          tmr_val  = acq_len;
        end
        SQ_ACQ: begin
          if (tmr_done) begin
            st_n     = SQ_CONV;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(CONV_CYC);
          end
        end
        SQ_CONV: begin
          if (tmr_done) begin
            st_n  = SQ_IDLE;
            cap_n = 1'b1;
            ok_n  = 1'b1;
          end
        end
        SQ_CAL, SQ_ZERO: begin
          if (core_done) st_n = SQ_IDLE;
        end
        SQ_PUP: begin
          if (tmr_done) st_n = SQ_IDLE;
        end
        default: st_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      cap_stb <= 1'b0;
      cap_ok  <= 1'b0;
    end else begin
      st      <= st_n;
      cap_stb <= cap_n;
      cap_ok  <= ok_n;
    end
  end

  assign eoc      = (st == SQ_IDLE);
  assign st_conv  = in_conv;
  assign st_cal   = (st == SQ_CAL);
  assign st_zero  = (st == SQ_ZERO);
  assign st_pwrup = (st == SQ_PUP);
  assign st_pwrdn = (st == SQ_PDN);

  AST_PD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pin |=> (st_pwrdn && !eoc)); // R7

  AST_SWUP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_pin && cmd_pwr_up) |=> st_pwrdn); // R8

  AST_SWDN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pwr_dn && !pd_pin) |=> st_pwrdn); // R9

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_conv && cs_fall && !pd_pin && !cmd_pwr_dn) |=> (eoc && cap_stb && !cap_ok)); // R5

  AST_CAP_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> $past(st_conv)); // R4

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_conv, st_cal, st_zero, st_pwrup, st_pwrdn})); // R12

  AST_BUSY_EOC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_conv || st_cal || st_zero || st_pwrup || st_pwrdn) |-> !eoc); // R2

  AST_CAL_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cal || st_zero) |=> !cap_stb); // R6

endmodule

// File: tb/cnv_cycle_seq_bench.sv
`timescale 1ns/100ps
module cnv_cycle_seq_bench;

  localparam int CONV_CYC  = 20;
  localparam int PWRUP_CYC = 40;
  localparam int P_CONV = 0, P_CAL = 1, P_ZERO = 2, P_UP = 3, P_DN = 4, P_CS = 5, P_DONE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_conv = 0, cmd_cal = 0, cmd_zero = 0, cmd_pwr_up = 0, cmd_pwr_dn = 0;
  logic [1:0] acq_sel = 2'd0;
  logic cs_fall = 0, pd_pin = 0, core_done = 0;
  logic eoc, st_conv, st_cal, st_zero, st_pwrup, st_pwrdn, cap_stb, cap_ok;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cnv_cycle_seq #(
    .ACQ_SEL_W (2),
    .CONV_CYC  (CONV_CYC),
    .PWRUP_CYC (PWRUP_CYC)
  ) u_cnv_cycle_seq (
    .clk(clk), .rst_n(rst_n), .cmd_conv(cmd_conv), .cmd_cal(cmd_cal),
    .cmd_zero(cmd_zero), .cmd_pwr_up(cmd_pwr_up), .cmd_pwr_dn(cmd_pwr_dn),
    .acq_sel(acq_sel), .cs_fall(cs_fall), .pd_pin(pd_pin), .core_done(core_done),
    .eoc(eoc), .st_conv(st_conv), .st_cal(st_cal), .st_zero(st_zero),
    .st_pwrup(st_pwrup), .st_pwrdn(st_pwrdn), .cap_stb(cap_stb), .cap_ok(cap_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int acq_of(input int code);
    case (code)
      0: return 6;
      1: return 10;
      2: return 18;
      default: return 34;
    endcase
  endfunction

  // Reference model: activity code and remaining cycles in the current phase.
  // 0 idle, 1 sync, 2 acquire, 3 convert, 4 cal, 5 zero, 6 power-up, 7 down
  int  m_act = 0;
  int  m_left = 0;
  bit  m_swdown = 0;
  bit  m_cap = 0, m_ok = 0;

  always @(posedge clk) begin
    bit  sw_next, off, conv_now;
    int  nact;
    if (!rst_n) begin
      m_act = 0; m_left = 0; m_swdown = 0; m_cap = 0; m_ok = 0;
    end else begin
      cycles++;
      sw_next  = pd_pin ? 1'b0 : (cmd_pwr_dn ? 1'b1 : (cmd_pwr_up ? 1'b0 : m_swdown));
      off      = pd_pin || sw_next;
      conv_now = (m_act >= 1 && m_act <= 3);
      nact = m_act;
      m_cap = 0; m_ok = 0;
      if (off) begin
        nact = 7;
        m_cap = conv_now;
      end else if (m_act == 7) begin
        nact = 6; m_left = PWRUP_CYC;
      end else if (conv_now && cs_fall) begin
        nact = 0; m_cap = 1;
      end else begin
        case (m_act)
          0: if (cmd_cal) nact = 4; else if (cmd_zero) nact = 5; else if (cmd_conv) nact = 1;
          1: begin nact = 2; m_left = acq_of(int'(acq_sel)); end
          2: begin m_left--; if (m_left == 0) begin nact = 3; m_left = CONV_CYC; end end
          3: begin m_left--; if (m_left == 0) begin nact = 0; m_cap = 1; m_ok = 1; end end
          4, 5: if (core_done) nact = 0;
          6: begin m_left--; if (m_left == 0) nact = 0; end
          default: nact = 0;
        endcase
      end
      m_act = nact;
      m_swdown = sw_next;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 eoc", int'(eoc), int'(m_act == 0));
      chk("R12 st_conv", int'(st_conv), int'(m_act >= 1 && m_act <= 3));
      chk("R6 st_cal", int'(st_cal), int'(m_act == 4));
      chk("R6 st_zero", int'(st_zero), int'(m_act == 5));
      chk("R10 st_pwrup", int'(st_pwrup), int'(m_act == 6));
      chk("R7 st_pwrdn", int'(st_pwrdn), int'(m_act == 7));
      chk("R4 cap_stb", int'(cap_stb), int'(m_cap));
      if (m_cap) chk("R4 cap_ok", int'(cap_ok), int'(m_ok));
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse(input int which);
    case (which)
      P_CONV: cmd_conv = 1;
      P_CAL:  cmd_cal = 1;
      P_ZERO: cmd_zero = 1;
      P_UP:   cmd_pwr_up = 1;
      P_DN:   cmd_pwr_dn = 1;
      P_CS:   cs_fall = 1;
      default: core_done = 1;
    endcase
    cyc(1);
    cmd_conv = 0; cmd_cal = 0; cmd_zero = 0; cmd_pwr_up = 0;
    cmd_pwr_dn = 0; cs_fall = 0; core_done = 0;
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (!eoc && n < 2000) begin n++; cyc(1); end
  endtask

  initial begin
    int n;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 eoc", int'(eoc), 1);
    chk("R1 flags", int'({st_conv, st_cal, st_zero, st_pwrup, st_pwrdn}), 0);
    chk("R1 cap", int'(cap_stb), 0);

    for (int s = 0; s < 4; s++) begin
      acq_sel = 2'(s);
      pulse(P_CONV);
      measure_low(n);
      chk("R3 length", n, 1 + acq_of(s) + CONV_CYC);
      chk("R4 strobe", int'(cap_stb), 1);
      chk("R4 ok", int'(cap_ok), 1);
      cyc(2);
    end

    acq_sel = 2'd0;
    pulse(P_CONV);
    cyc(3);
    pulse(P_CAL);
    pulse(P_CONV);
    measure_low(n);
    chk("R11 ignored while busy", n, 1 + 6 + CONV_CYC - 5);

    pulse(P_CONV);
    cyc(5);
    pulse(P_CS);
    chk("R5 abort eoc", int'(eoc), 1);
    chk("R5 abort strobe", int'(cap_stb), 1);
    chk("R5 abort ok", int'(cap_ok), 0);
    cyc(1);
    pulse(P_CS);
    chk("R5 idle cs eoc", int'(eoc), 1);
    chk("R5 idle cs cap", int'(cap_stb), 0);

    pulse(P_CAL);
    chk("R6 cal busy", int'(st_cal && !eoc), 1);
    cyc(4);
    chk("R6 cal waits", int'(st_cal), 1);
    pulse(P_DONE);
    chk("R6 cal end eoc", int'(eoc), 1);
    chk("R6 cal no cap", int'(cap_stb), 0);
    pulse(P_ZERO);
    chk("R6 zero busy", int'(st_zero && !eoc), 1);
    pulse(P_DONE);
    chk("R6 zero end", int'(eoc), 1);
    pulse(P_DONE);
    chk("R6 done idle", int'(eoc && !cap_stb), 1);
    pulse(P_CAL);
    pulse(P_ZERO);
    pulse(P_DONE);
    chk("R11 precedence", int'(eoc), 1);

    pulse(P_CONV);
    cyc(3);
    pd_pin = 1;
    cyc(1);
    chk("R7 pd down", int'(st_pwrdn && !eoc), 1);
    chk("R7 corrupt strobe", int'(cap_stb), 1);
    chk("R7 corrupt ok", int'(cap_ok), 0);
    pulse(P_UP);
    chk("R8 up ignored", int'(st_pwrdn), 1);
    cyc(3);
    chk("R8 stays down", int'(st_pwrdn), 1);
    pd_pin = 0;
    cyc(1);
    chk("R10 pin restore", int'(st_pwrup), 1);
    measure_low(n);
    chk("R10 pwrup length", n, PWRUP_CYC);

    pulse(P_DN);
    chk("R9 sw down", int'(st_pwrdn && !eoc), 1);
    pulse(P_CONV);
    chk("R11 conv ignored down", int'(st_pwrdn && !st_conv), 1);
    cyc(5);
    chk("R9 holds", int'(st_pwrdn), 1);
    pulse(P_UP);
    chk("R10 sw up", int'(st_pwrup), 1);
    measure_low(n);
    chk("R10 sw pwrup length", n, PWRUP_CYC);

    pulse(P_CONV);
    cyc(2);
    pulse(P_DN);
    chk("R9 corrupt strobe", int'(cap_stb && !cap_ok), 1);
    cyc(2);
    pd_pin = 1;
    cyc(2);
    pd_pin = 0;
    cyc(1);
    chk("R10 pulse restore", int'(st_pwrup), 1);
    measure_low(n);
    chk("R10 pulse length", n, PWRUP_CYC);
    cyc(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cycles > 100000) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule